// File: doc/BRIEF.md
# Write Queue with Read Envelope

This block sits on the master side of a bus whose address and data phases are granted separately. It keeps up to four pending writes: ordinary stores and snoop push-outs of modified lines. It asks for the address bus and places write addresses there in queue order. A push-out is placed ahead of every ordinary write that has not yet had its address phase. Data for each write goes out on a later data bus grant, in the same order as the address phases.

The block also tracks one outstanding read. A separate arbiter grants the data bus. When that grant comes with the write-only ordering input high, the block sends the oldest addressed write instead of taking the read's data, so one or more writes can be slipped in ahead of the read. When the grant comes with that input low, it goes to the read. When no read is pending, every data grant serves writes. A write leaves the queue only after its data beat is acknowledged.

Top module: `wq_envelope`

## Requirements
- R1: Asserting reset (rst_n low, asynchronous) empties the queue and clears the read flag: wr_ready and sp_ready high, abus_req, dbus_req, dbus_wvalid, dbus_read_go and rd_pending low.
- R2: abus_req is high while any queued entry has had no address phase. abus_addr shows the oldest such entry, and abus_fire is high in the cycle abus_gnt arrives while abus_req is high.
- R3: A push-out is inserted behind entries that already had an address phase and behind earlier unaddressed push-outs, but ahead of all unaddressed ordinary writes. abus_push is 1 while abus_addr shows a push-out. When both enqueue inputs are valid, the push-out is taken and wr_ready is low.
- R4: The queue holds DEPTH (4) entries. With 4 entries held, wr_ready and sp_ready are low and no enqueue takes place.
- R5: Write data beats go out in the order of their address phases, and dbus_wdata carries the data enqueued with that address.
- R6: A data grant with dbus_wonly high starts the beat of the oldest addressed write even while a read is pending. Several such beats may precede the read's data, and the read stays pending.
- R7: A data grant with dbus_wonly low while a read is pending raises dbus_read_go in the same cycle and starts no write beat.
- R8: A data grant with no read pending starts the beat of the oldest addressed write, whatever the level of dbus_wonly.
- R9: dbus_wvalid rises the cycle after the granting cycle and holds dbus_wdata steady until dbus_ack. The entry is retired at that edge. dbus_req is low while a beat is active.
- R10: rd_pending is set by rd_issued and cleared by rd_done.
- R11: A data grant with dbus_wonly high and no addressed write starts nothing: no beat and no dbus_read_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Ordinary write offered |
| wr_ready | output | 1 | Ordinary write accepted |
| wr_addr | input | AW | Ordinary write address |
| wr_data | input | DW | Ordinary write data |
| sp_valid | input | 1 | Snoop push-out offered |
| sp_ready | output | 1 | Push-out accepted |
| sp_addr | input | AW | Push-out address |
| sp_data | input | DW | Push-out data |
| rd_issued | input | 1 | Read address phase done, read now pending |
| rd_done | input | 1 | Read completed |
| rd_pending | output | 1 | A read is outstanding |
| abus_req | output | 1 | Address bus request |
| abus_gnt | input | 1 | Address bus grant |
| abus_fire | output | 1 | Write address driven this cycle |
| abus_addr | output | AW | Write address |
| abus_push | output | 1 | Address belongs to a push-out |
| dbus_req | output | 1 | Data bus request |
| dbus_gnt | input | 1 | Data bus grant |
| dbus_wonly | input | 1 | Grant is for write data only |
| dbus_read_go | output | 1 | Grant consumed by the pending read |
| dbus_wvalid | output | 1 | Write beat active |
| dbus_wdata | output | DW | Write beat data |
| dbus_ack | input | 1 | Write beat accepted |

## Verification
The embedded properties assume that the environment sends rd_issued only when no read is outstanding, sends rd_done only while one is, and sends dbus_ack only while dbus_wvalid is high. The stimulus keeps to these rules: reads are issued and completed only in the matching state, and every acknowledge is placed in a cycle where a beat is visible. Grants without a request are allowed, and the stimulus sends some on purpose to show that they are ignored.

// File: rtl/wq_envelope.sv
module wq_envelope #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sp_valid,
  output logic          sp_ready,
  input  logic [AW-1:0] sp_addr,
  input  logic [DW-1:0] sp_data,
  input  logic          rd_issued,
  input  logic          rd_done,
  output logic          rd_pending,
  output logic          abus_req,
  input  logic          abus_gnt,
  output logic          abus_fire,
  output logic [AW-1:0] abus_addr,
  output logic          abus_push,
  output logic          dbus_req,
  input  logic          dbus_gnt,
  input  logic          dbus_wonly,
  output logic          dbus_read_go,
  output logic          dbus_wvalid,
  output logic [DW-1:0] dbus_wdata,
  input  logic          dbus_ack
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [CW-1:0] ones(input logic [DEPTH-1:0] x);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DEPTH; i++) c = c + CW'(x[i]);
    return c;
  endfunction

  logic [DEPTH-1:0] q_v, q_ad, q_ps;
  logic [AW-1:0]    q_a [DEPTH];
  logic [DW-1:0]    q_d [DEPTH];
  logic             busy, rd_pend;

  logic [DEPTH-1:0] t_v, t_ad, t_ps, n_v, n_ad, n_ps;
  logic [AW-1:0]    t_a [DEPTH];
  logic [DW-1:0]    t_d [DEPTH];
  logic [AW-1:0]    n_a [DEPTH];
  logic [DW-1:0]    n_d [DEPTH];
  logic [CW-1:0]    pos;

  wire [CW-1:0] n_valid = ones(q_v);
  wire [CW-1:0] n_addr  = ones(q_v & q_ad);
  wire          full    = (n_valid == CW'(DEPTH));
  wire          head_rdy = q_v[0] & q_ad[0];
  wire          wgo     = dbus_gnt & ~busy & head_rdy & (dbus_wonly | ~rd_pend);
  wire          retire  = busy & dbus_ack;
  wire          ins_p   = sp_valid & sp_ready;
  wire          ins_w   = wr_valid & wr_ready;
  wire [IW-1:0] a_idx   = abus_req ? n_addr[IW-1:0] : '0;

  assign sp_ready     = ~full;
  assign wr_ready     = ~full & ~sp_valid;
  assign abus_req     = (n_addr != n_valid);
  assign abus_fire    = abus_req & abus_gnt;
  assign abus_addr    = q_a[a_idx];
  assign abus_push    = q_ps[a_idx];
  assign dbus_req     = ~busy & (rd_pend | head_rdy);
  assign dbus_read_go = dbus_gnt & ~busy & ~dbus_wonly & rd_pend;
  assign dbus_wvalid  = busy;
  assign dbus_wdata   = q_d[0];
  assign rd_pending   = rd_pend;

  always_comb begin
    t_v = q_v; t_ad = q_ad; t_ps = q_ps; t_a = q_a; t_d = q_d;
    if (abus_fire) t_ad[a_idx] = 1'b1;
    if (retire) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        t_v[i] = t_v[i+1]; t_ad[i] = t_ad[i+1]; t_ps[i] = t_ps[i+1];
        t_a[i] = t_a[i+1]; t_d[i] = t_d[i+1];
      end
      t_v[DEPTH-1] = 1'b0; t_ad[DEPTH-1] = 1'b0; t_ps[DEPTH-1] = 1'b0;
    end
    pos = ins_p ? ones(t_v & (t_ad | t_ps)) : ones(t_v);
    n_v = t_v; n_ad = t_ad; n_ps = t_ps; n_a = t_a; n_d = t_d;
    if (ins_p | ins_w) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (CW'(i) > pos) begin
          n_v[i] = t_v[i-1]; n_ad[i] = t_ad[i-1]; n_ps[i] = t_ps[i-1];
          n_a[i] = t_a[i-1]; n_d[i] = t_d[i-1];
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == pos) begin
          n_v[i] = 1'b1; n_ad[i] = 1'b0; n_ps[i] = ins_p;
          n_a[i] = ins_p ? sp_addr : wr_addr;
          n_d[i] = ins_p ? sp_data : wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v <= '0; q_ad <= '0; q_ps <= '0;
      busy <= 1'b0; rd_pend <= 1'b0;
    end else begin
      q_v <= n_v; q_ad <= n_ad; q_ps <= n_ps;
      if (wgo) busy <= 1'b1;
      else if (retire) busy <= 1'b0;
      if (rd_issued) rd_pend <= 1'b1;
      else if (rd_done) rd_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    q_a <= n_a;
    q_d <= n_d;
  end

  p_push_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (abus_fire && !abus_push) |-> ((q_v & q_ps & ~q_ad) == '0));

  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !retire) |=> !sp_ready);

  p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_v & (q_v + 1'b1)) == '0) && ((q_ad & ~q_v) == '0) && ((q_ad & (q_ad + 1'b1)) == '0));

  p_wonly_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_wonly |-> !dbus_read_go);

  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_wvalid && !dbus_ack) |=> (dbus_wvalid && $stable(dbus_wdata)));

  p_beat_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_wvalid && dbus_ack) |=> !dbus_wvalid);

  p_no_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_wvalid |-> !dbus_req);

  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_issued) |=> !rd_pending);

endmodule

// File: tb/wq_envelope_bench.sv
module wq_envelope_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, sp_valid = 0, rd_issued = 0, rd_done = 0;
  logic abus_gnt = 0, dbus_gnt = 0, dbus_wonly = 0, dbus_ack = 0;
  logic [7:0] wr_addr = 0, sp_addr = 0;
  logic [15:0] wr_data, sp_data;
  logic wr_ready, sp_ready, rd_pending, abus_req, abus_fire, abus_push;
  logic dbus_req, dbus_read_go, dbus_wvalid;
  logic [7:0] abus_addr;
  logic [15:0] dbus_wdata;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] dat(input logic [7:0] a);
    return {a ^ 8'hA5, a};
  endfunction
  assign wr_data = dat(wr_addr);
  assign sp_data = dat(sp_addr);

  wq_envelope u_wq_envelope (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_addr(sp_addr), .sp_data(sp_data),
    .rd_issued(rd_issued), .rd_done(rd_done), .rd_pending(rd_pending),
    .abus_req(abus_req), .abus_gnt(abus_gnt), .abus_fire(abus_fire),
    .abus_addr(abus_addr), .abus_push(abus_push),
    .dbus_req(dbus_req), .dbus_gnt(dbus_gnt), .dbus_wonly(dbus_wonly),
    .dbus_read_go(dbus_read_go), .dbus_wvalid(dbus_wvalid),
    .dbus_wdata(dbus_wdata), .dbus_ack(dbus_ack)
  );

  typedef struct packed {
    logic wv; logic [7:0] wa; logic sv; logic [7:0] sa;
    logic ri, rdn, ag, dg, wo, ack;
    logic wrdy, srdy, areq, afire; logic [7:0] aadr; logic apush;
    logic dreq, rgo, wvld; logic [7:0] badr; logic rpend;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0,0,0},
    '{1,10,0,0,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0,0,0},
    '{1,11,0,0,0,0,0,0,0,0, 1,1,1,0,10,0,0,0,0,0,0},
    '{1,12,0,0,1,0,0,0,0,0, 1,1,1,0,10,0,0,0,0,0,0},
    '{0,0,0,0,0,0,1,0,0,0, 1,1,1,1,10,0,1,0,0,0,1},
    '{1,13,1,20,0,0,0,0,0,0, 0,1,1,0,11,0,1,0,0,0,1},
    '{1,13,0,0,0,0,0,0,0,0, 0,0,1,0,20,1,1,0,0,0,1},
    '{0,0,0,0,0,0,1,0,0,0, 0,0,1,1,20,1,1,0,0,0,1},
    '{0,0,0,0,0,0,1,0,0,0, 0,0,1,1,11,0,1,0,0,0,1},
    '{0,0,0,0,0,0,0,1,1,0, 0,0,1,0,12,0,1,0,0,0,1},
    '{0,0,0,0,0,0,0,0,0,0, 0,0,1,0,12,0,0,0,1,10,1},
    '{0,0,0,0,0,0,0,0,0,1, 0,0,1,0,12,0,0,0,1,10,1},
    '{0,0,0,0,0,0,0,1,1,0, 1,1,1,0,12,0,1,0,0,0,1},
    '{0,0,0,0,0,0,0,0,0,1, 1,1,1,0,12,0,0,0,1,20,1},
    '{0,0,0,0,0,0,0,1,0,0, 1,1,1,0,12,0,1,1,0,0,1},
    '{0,0,0,0,0,1,0,0,0,0, 1,1,1,0,12,0,1,0,0,0,1},
    '{0,0,0,0,0,0,0,1,0,0, 1,1,1,0,12,0,1,0,0,0,0},
    '{0,0,0,0,0,0,1,0,0,1, 1,1,1,1,12,0,0,0,1,11,0},
    '{0,0,0,0,0,0,0,1,1,0, 1,1,0,0,0,0,1,0,0,0,0},
    '{0,0,0,0,0,0,0,0,0,1, 1,1,0,0,0,0,0,0,1,12,0},
    '{0,0,0,0,0,0,0,1,1,0, 1,1,0,0,0,0,0,0,0,0,0},
    '{0,0,0,0,0,0,0,0,0,0, 1,1,0,0,0,0,0,0,0,0,0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; sp_valid = 0; rd_issued = 0; rd_done = 0;
    abus_gnt = 0; dbus_gnt = 0; dbus_wonly = 0; dbus_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ord_a [4];
    logic       ord_p [4];
    ord_a = '{8'd40, 8'd41, 8'd30, 8'd31};
    ord_p = '{1'b1, 1'b1, 1'b0, 1'b0};
    idle();
    #1;
    chk("R1 reset wr_ready", wr_ready, 1);
    chk("R1 reset abus_req", abus_req, 0);
    chk("R1 reset rd_pending", rd_pending, 0);
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      @(negedge clk);
      wr_valid = v.wv; wr_addr = v.wa; sp_valid = v.sv; sp_addr = v.sa;
      rd_issued = v.ri; rd_done = v.rdn; abus_gnt = v.ag;
      dbus_gnt = v.dg; dbus_wonly = v.wo; dbus_ack = v.ack;
      #1;
      chk("R4 wr_ready", wr_ready, v.wrdy);
      chk("R4 sp_ready", sp_ready, v.srdy);
      chk("R2 abus_req", abus_req, v.areq);
      chk("R2 abus_fire", abus_fire, v.afire);
      if (v.areq) begin
        chk("R2 abus_addr", abus_addr, v.aadr);
        chk("R3 abus_push", abus_push, v.apush);
      end
      chk("R9 dbus_req", dbus_req, v.dreq);
      chk("R7 dbus_read_go", dbus_read_go, v.rgo);
      chk("R5 dbus_wvalid", dbus_wvalid, v.wvld);
      if (v.wvld) chk("R5 dbus_wdata", dbus_wdata, dat(v.badr));
      chk("R10 rd_pending", rd_pending, v.rpend);
    end

    // R1: reset while occupied
    @(negedge clk); idle(); wr_valid = 1; wr_addr = 8'd50;
    @(negedge clk); wr_addr = 8'd51; rd_issued = 1;
    @(negedge clk); idle(); rst_n = 0; #1;
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 sp_ready", sp_ready, 1);
    chk("R1 abus_req", abus_req, 0);
    chk("R1 dbus_req", dbus_req, 0);
    chk("R1 rd_pending", rd_pending, 0);
    chk("R1 dbus_wvalid", dbus_wvalid, 0);
    @(negedge clk); rst_n = 1;

    // R11: write-only grant with nothing addressed
    @(negedge clk); rd_issued = 1;
    @(negedge clk); rd_issued = 0; dbus_gnt = 1; dbus_wonly = 1; #1;
    chk("R11 dbus_read_go", dbus_read_go, 0);
    @(negedge clk); idle(); #1;
    chk("R11 dbus_wvalid", dbus_wvalid, 0);
    chk("R10 rd_pending", rd_pending, 1);

    // R3: push-outs overtake unaddressed writes
    @(negedge clk); wr_valid = 1; wr_addr = 8'd30;
    @(negedge clk); wr_addr = 8'd31;
    @(negedge clk); wr_valid = 0; sp_valid = 1; sp_addr = 8'd40;
    @(negedge clk); sp_addr = 8'd41;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); idle(); abus_gnt = 1; #1;
      chk("R3 abus_addr order", abus_addr, ord_a[j]);
      chk("R3 abus_push", abus_push, ord_p[j]);
    end

    // R6: two beats enveloped by the pending read
    @(negedge clk); idle(); dbus_gnt = 1; dbus_wonly = 1;
    @(negedge clk); idle(); #1;
    chk("R6 first beat valid", dbus_wvalid, 1);
    chk("R6 first beat data", dbus_wdata, dat(8'd40));
    dbus_ack = 1;
    @(negedge clk); idle(); dbus_gnt = 1; dbus_wonly = 1;
    @(negedge clk); idle(); #1;
    chk("R6 second beat valid", dbus_wvalid, 1);
    chk("R6 second beat data", dbus_wdata, dat(8'd41));
    chk("R6 read still pending", rd_pending, 1);
    dbus_ack = 1;
    // R7: ordinary grant goes to the read
    @(negedge clk); idle(); dbus_gnt = 1; #1;
    chk("R7 dbus_read_go", dbus_read_go, 1);
    @(negedge clk); idle(); #1;
    chk("R7 no write beat", dbus_wvalid, 0);
    rd_done = 1;
    // R8: no read pending, ordinary grant serves a write
    @(negedge clk); idle(); dbus_gnt = 1; #1;
    chk("R10 rd_pending cleared", rd_pending, 0);
    chk("R8 dbus_read_go", dbus_read_go, 0);
    @(negedge clk); idle(); #1;
    chk("R8 beat valid", dbus_wvalid, 1);
    chk("R8 beat data", dbus_wdata, dat(8'd30));
    @(negedge clk); #1;
    chk("R9 beat held", dbus_wvalid, 1);
    chk("R9 dbus_req low", dbus_req, 0);
    dbus_ack = 1;
    @(negedge clk); idle(); #1;
    chk("R9 beat ended", dbus_wvalid, 0);
    chk("R9 next request", dbus_req, 1);

    @(negedge clk);
    finish_run();
  end
endmodule